// File: doc/BRIEF.md
# Address-Stability Automatic Sleep Controller

This block sits in the read path of a flash array and puts it into a low-power state without any command from the host. It registers the address bus on every clock and counts how many cycles the address has stayed unchanged. After a full access time has passed, the sensed array word is captured in an output holding register. Once the address has been stable for the access time plus a fixed margin, the block enters sleep and turns off the array sense path. The holding register keeps driving the last word, so read data stays available while the array is idle.

Any change on any address bit ends sleep at once and starts a normal access with the usual access latency. The outputs show the previous word until the new access completes. The chip-enable, write-enable and output-enable strobes only affect whether the output drivers are enabled. They play no part in entering or leaving sleep. A busy flag from the program/erase engine holds the block active until the operation ends.

The control is a three-state machine:
- ACCESS: the sense path is on and an access is in progress.
- ACTIVE: the data is valid and latched, and the sense path is still on.
- SLEEP: the sense path is off and the latched data is held.

The transitions are:
- ACCESS to ACTIVE ("access done") when the access time has elapsed with a stable address. The output register loads on this transition.
- ACTIVE to SLEEP ("idle timeout") when the stability count reaches the threshold and the busy flag is low.
- ACCESS, ACTIVE or SLEEP to ACCESS ("address change") on any address difference.
- Each state holds itself otherwise.

Reset places the machine in ACCESS with the count at zero.

Top module: `asp_sleep_ctrl`

## Requirements
- R1: While rst_n is low, and after it rises until the first access completes, sleep_o is 0, sense_en is 1 and dq_o is 0.
- R2: The stability count clears on a change in any single address bit. Sleep needs a full uninterrupted window of THR = T_ACC + MARGIN stable cycles. Once reached, the count saturates: sleep lasts any length of time without wrapping and ending.
- R3: A new address is registered on the first rising edge after it appears (edge 0). With the address unchanged, sleep_o rises and sense_en falls after edge THR, and not earlier.
- R4: dq_o keeps its previous value through edge T_ACC-1. After edge T_ACC, it equals the arr_rdata word presented for the new address.
- R5: An address change while asleep clears sleep_o and sets sense_en after the next rising edge. This starts a normal access with the R4 timing.
- R6: While asleep, dq_o does not change, whatever arr_rdata does.
- R7: ce_n, we_n and oe_n have no effect on the timing of sleep entry or exit.
- R8: dq_oe is 1 only when ce_n=0, oe_n=0 and we_n=1. It is 0 when oe_n=1, asleep or awake. The held word is the same after the driver is enabled again.
- R9: While pgm_busy is 1, the block does not enter sleep. If the stability window has already elapsed, sleep_o rises after the first edge at which pgm_busy is sampled 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Read address bus |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| pgm_busy | input | 1 | Program/erase operation in progress |
| arr_rdata | input | DW | Word sensed from the array |
| sense_en | output | 1 | Enables the array sense path |
| sleep_o | output | 1 | Block is in automatic sleep |
| dq_o | output | DW | Held read data |
| dq_oe | output | 1 | Output driver enable (0 = high impedance) |

## Verification
The bench moves the address one cycle before the sleep threshold, flipping only the top bit and then only the bottom bit. A design that failed to clear the counter on a single-bit change would fall asleep early. It corrupts the array word while the block is asleep and waits long past the threshold. A design that reloaded the latch would show the corrupted word, and a counter that wrapped would drop out of sleep. It checks the old word one edge before access completion and the new word one edge after. This catches latches that load early or late. It toggles the strobes during the stability window and holds the busy flag past the threshold. A design that let either one gate sleep would enter sleep at the wrong edge.

// File: rtl/asp_pkg.sv
`timescale 1ns/1ps
package asp_pkg;
    typedef enum logic [1:0] {
        ST_ACCESS = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_SLEEP  = 2'd2
    } asp_state_e;
endpackage

// File: rtl/asp_stab_cnt.sv
`timescale 1ns/1ps
// Registers the address and counts cycles for which it stays unchanged.
module asp_stab_cnt #(
    parameter int AW    = 16,
    parameter int T_ACC = 4,
    parameter int THR   = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [AW-1:0]                addr,
    output logic                         addr_chg,
    output logic                         acc_done,
    output logic                         thr_hit
);
    localparam int CW = $clog2(THR + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(THR);
    localparam logic [CW-1:0] ACC_LIM = CW'(T_ACC - 1);
    localparam logic [CW-1:0] THR_LIM = CW'(THR - 1);

    logic [AW-1:0] addr_q;
    logic [CW-1:0] cnt;

    assign addr_chg = (addr != addr_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt    <= '0;
        end else begin
            addr_q <= addr;
            if (addr_chg) begin
                cnt <= '0;
            end else if (cnt != CNT_MAX) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Flags are evaluated on the count before the current edge.
    assign acc_done = (cnt >= ACC_LIM);
    assign thr_hit  = (cnt >= THR_LIM);
endmodule

// File: rtl/asp_fsm.sv
`timescale 1ns/1ps
// Access / active / sleep state machine.
module asp_fsm
    import asp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic addr_chg,
    input  logic acc_done,
    input  logic thr_hit,
    input  logic pgm_busy,
    output logic sense_en,
    output logic sleep_o,
    output logic load_en
);
    asp_state_e state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_ACCESS;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_ACCESS: begin
                if (!addr_chg && acc_done) begin
                    state_nxt = ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (addr_chg) begin
                    state_nxt = ST_ACCESS;
                end else if (thr_hit && !pgm_busy) begin
                    state_nxt = ST_SLEEP;
                end
            end
            ST_SLEEP: begin
                if (addr_chg) begin
                    state_nxt = ST_ACCESS;
                end
            end
            default: state_nxt = ST_ACCESS;
        endcase
    end

    always_comb begin
        sleep_o  = (state == ST_SLEEP);
        sense_en = (state != ST_SLEEP);
        load_en  = (state == ST_ACCESS) && !addr_chg && acc_done;
    end
endmodule

// File: rtl/asp_out_latch.sv
`timescale 1ns/1ps
// Holds the last completed read word and gates the output drivers.
module asp_out_latch #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [DW-1:0] arr_rdata,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    output logic [DW-1:0] dq_o,
    output logic          dq_oe
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dq_o <= '0;
        end else if (load_en) begin
            dq_o <= arr_rdata;
        end
    end

    assign dq_oe = !ce_n && !oe_n && we_n;
endmodule

// File: rtl/asp_sleep_ctrl.sv
`timescale 1ns/1ps
module asp_sleep_ctrl #(
    parameter int AW     = 16,
    parameter int DW     = 16,
    parameter int T_ACC  = 4,
    parameter int MARGIN = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic          pgm_busy,
    input  logic [DW-1:0] arr_rdata,
    output logic          sense_en,
    output logic          sleep_o,
    output logic [DW-1:0] dq_o,
    output logic          dq_oe
);
    localparam int THR = T_ACC + MARGIN;

    logic addr_chg;
    logic acc_done;
    logic thr_hit;
    logic load_en;

    asp_stab_cnt #(.AW(AW), .T_ACC(T_ACC), .THR(THR)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .addr_chg (addr_chg),
        .acc_done (acc_done),
        .thr_hit  (thr_hit)
    );

    asp_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_chg (addr_chg),
        .acc_done (acc_done),
        .thr_hit  (thr_hit),
        .pgm_busy (pgm_busy),
        .sense_en (sense_en),
        .sleep_o  (sleep_o),
        .load_en  (load_en)
    );

    asp_out_latch #(.DW(DW)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .arr_rdata (arr_rdata),
        .ce_n      (ce_n),
        .we_n      (we_n),
        .oe_n      (oe_n),
        .dq_o      (dq_o),
        .dq_oe     (dq_oe)
    );
endmodule

// File: rtl/asp_sleep_chk.sv
`timescale 1ns/1ps
module asp_sleep_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          addr_chg,
    input logic          load_en,
    input logic          pgm_busy,
    input logic          sleep_o,
    input logic [DW-1:0] dq_o
);
    p_wake_on_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
        addr_chg |=> !sleep_o);

    p_hold_in_sleep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_o |=> $stable(dq_o));

    p_load_after_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dq_o) |-> $past(load_en));

    p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_busy && !sleep_o) |=> !sleep_o);
endmodule

module asp_cnt_chk #(
    parameter int THR = 6
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       addr_chg,
    input logic [$clog2(THR+1)-1:0]   cnt
);
    localparam int CW = $clog2(THR + 1);

    p_cnt_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_chg |=> (cnt == '0));

    p_cnt_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(THR));

    p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_chg && cnt < CW'(THR)) |=> (cnt == CW'($past(cnt) + 1'b1)));
endmodule

bind asp_sleep_ctrl asp_sleep_chk #(.DW(DW)) u_sleep_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_chg (addr_chg),
    .load_en  (load_en),
    .pgm_busy (pgm_busy),
    .sleep_o  (sleep_o),
    .dq_o     (dq_o)
);

bind asp_stab_cnt asp_cnt_chk #(.THR(THR)) u_cnt_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_chg (addr_chg),
    .cnt      (cnt)
);

// File: tb/asp_sleep_ctrl_tb.sv
`timescale 1ns/1ps
module asp_sleep_ctrl_tb;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int T_ACC = 4;
    localparam int MARGIN = 2;
    localparam int THR = T_ACC + MARGIN;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          ce_n = 1'b0;
    logic          we_n = 1'b1;
    logic          oe_n = 1'b0;
    logic          pgm_busy = 1'b0;
    logic          data_ovr = 1'b0;
    logic [DW-1:0] ovr_val = '0;
    logic [DW-1:0] arr_rdata;
    logic          sense_en, sleep_o, dq_oe;
    logic [DW-1:0] dq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    function automatic logic [DW-1:0] model(input logic [AW-1:0] a);
        return (a * 16'h0101) ^ 16'h5A3C;
    endfunction

    assign arr_rdata = data_ovr ? ovr_val : model(addr);

    asp_sleep_ctrl #(.AW(AW), .DW(DW), .T_ACC(T_ACC), .MARGIN(MARGIN)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .we_n(we_n),
        .oe_n(oe_n), .pgm_busy(pgm_busy), .arr_rdata(arr_rdata),
        .sense_en(sense_en), .sleep_o(sleep_o), .dq_o(dq_o), .dq_oe(dq_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        addr = '0;
        edges(3);
        chk("R1 sleep in reset", 32'(sleep_o), 32'd0);
        chk("R1 sense in reset", 32'(sense_en), 32'd1);
        chk("R1 dq in reset", 32'(dq_o), 32'd0);
        rst_n = 1'b1;
        edges(T_ACC - 1);
        chk("R1 dq before first access", 32'(dq_o), 32'd0);
        chk("R1 awake after reset", 32'(sleep_o), 32'd0);
        edges(THR + 2);
        chk("R4 reset address loaded", 32'(dq_o), 32'(model('0)));
    endtask

    task automatic t_access();
        logic [DW-1:0] prev = dq_o;
        addr = 16'h1234;
        edges(T_ACC);
        chk("R4 old word before access done", 32'(dq_o), 32'(prev));
        edges(1);
        chk("R4 new word after access", 32'(dq_o), 32'(model(16'h1234)));
        edges(THR - T_ACC - 1);
        chk("R3 no sleep at edge THR-1", 32'(sleep_o), 32'd0);
        edges(1);
        chk("R3 sleep at edge THR", 32'(sleep_o), 32'd1);
        chk("R3 sense off in sleep", 32'(sense_en), 32'd0);
    endtask

    task automatic t_restart();
        addr = 16'h1234 ^ 16'h8000;
        edges(THR);
        chk("R2 not asleep yet", 32'(sleep_o), 32'd0);
        addr = addr ^ 16'h0001;
        edges(THR);
        chk("R2 window restarted by one-bit change", 32'(sleep_o), 32'd0);
        edges(1);
        chk("R2 sleep after full window", 32'(sleep_o), 32'd1);
    endtask

    task automatic t_wake_hold();
        logic [DW-1:0] old = dq_o;
        addr = 16'hC0DE;
        edges(1);
        chk("R5 wake after change", 32'(sleep_o), 32'd0);
        chk("R5 sense on after change", 32'(sense_en), 32'd1);
        edges(T_ACC - 1);
        chk("R5 old word during access", 32'(dq_o), 32'(old));
        edges(1);
        chk("R5 new word after wake access", 32'(dq_o), 32'(model(16'hC0DE)));
        edges(THR - T_ACC);
        chk("R5 asleep again", 32'(sleep_o), 32'd1);
        ovr_val = 16'hDEAD;
        data_ovr = 1'b1;
        edges(5);
        chk("R6 word held while array data changes", 32'(dq_o), 32'(model(16'hC0DE)));
        edges(40);
        chk("R2 saturated count keeps sleep", 32'(sleep_o), 32'd1);
        chk("R6 word held over long sleep", 32'(dq_o), 32'(model(16'hC0DE)));
        data_ovr = 1'b0;
    endtask

    task automatic t_ctrl();
        addr = 16'h0F0F;
        for (int i = 0; i < THR; i++) begin
            {ce_n, we_n, oe_n} = 3'(i + 3);
            edges(1);
        end
        chk("R7 strobes do not advance sleep", 32'(sleep_o), 32'd0);
        {ce_n, we_n, oe_n} = 3'b010;
        edges(1);
        chk("R7 strobes do not delay sleep", 32'(sleep_o), 32'd1);
        ce_n = 1'b1;
        oe_n = 1'b1;
        edges(3);
        chk("R7 deselect keeps sleep", 32'(sleep_o), 32'd1);
        ce_n = 1'b0;
        oe_n = 1'b0;
    endtask

    task automatic t_oe();
        logic [DW-1:0] held = dq_o;
        #1;
        chk("R8 driver on when selected", 32'(dq_oe), 32'd1);
        oe_n = 1'b1; #1;
        chk("R8 oe high floats outputs in sleep", 32'(dq_oe), 32'd0);
        oe_n = 1'b0; ce_n = 1'b1; #1;
        chk("R8 ce high floats outputs", 32'(dq_oe), 32'd0);
        ce_n = 1'b0; we_n = 1'b0; #1;
        chk("R8 we low floats outputs", 32'(dq_oe), 32'd0);
        we_n = 1'b1; #1;
        chk("R8 held word after re-enable", 32'(dq_o), 32'(held));
        chk("R8 driver back on", 32'(dq_oe), 32'd1);
        @(negedge clk);
        addr = 16'h4444;
        edges(2);
        oe_n = 1'b1; #1;
        chk("R8 oe high floats outputs while awake", 32'(dq_oe), 32'd0);
        oe_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_busy();
        addr = 16'h7777;
        pgm_busy = 1'b1;
        edges(THR + 1);
        chk("R9 busy blocks sleep at threshold", 32'(sleep_o), 32'd0);
        edges(10);
        chk("R9 busy keeps active", 32'(sleep_o), 32'd0);
        pgm_busy = 1'b0;
        edges(1);
        chk("R9 sleep once busy ends", 32'(sleep_o), 32'd1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_access();
        t_restart();
        t_wake_hold();
        t_ctrl();
        t_oe();
        t_busy();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule